// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the line reservations that a cache controller needs for load-linked / store-conditional pairs and for locked read-modify-write sequences. A small table holds the locked lines. Each entry carries the line address (offset bits dropped) and the identifier of the requester that took the lock. The controller reports every request completion on one completion port. It reports each loss of coherence permission on a second port. The block answers each completion with a pass/fail result one cycle later.

A store-conditional passes only while its own requester still holds the line. Every store-conditional gives up the lock, whether it passes or fails. Ordinary writes by the owner also drop the lock, and so does a permission loss on a line that has a store-conditional pending. When the table is full, a new load-linked takes the slot of the oldest surviving entry. A locked read raises a block on its line, which tells the controller to hold back new requests to that line until the matching locked write completes. A configuration input turns the reservation logic off. Every operation then passes and the table is left alone.

Completion kinds on `cmp_kind`: 0 load-linked, 1 store-conditional, 2 plain store, 3 locked read, 4 locked write. Codes 5 to 7 act as plain stores.

Top module: `llsc_resv_monitor`

## Requirements
- R1: Every completion accepted with `cmp_valid` high at a clock edge gives `res_valid`=1 in the following cycle, and `res_valid` is 0 otherwise. `res_ok` is 1 for every kind other than store-conditional (kind 1). In particular a load-linked (kind 0) always passes.
- R2: A store-conditional gives `res_ok`=1 only if its line holds a lock tagged with the same `cmp_req`. Otherwise it gives `res_ok`=0.
- R3: Every store-conditional removes the lock on its line, pass or fail. A second store-conditional to the same line then fails.
- R4: A completion of kind 2, 3, 4 or 5–7 removes the lock on its line only when `cmp_line_present`=1 and the lock is tagged with the same `cmp_req`. With another requester, or with the line absent, the lock stays.
- R5: `loss_valid` with `loss_sc_pending`=1 removes the lock on the line of `loss_addr`. With `loss_sc_pending`=0 it has no effect. If a load-linked to that same line completes in the same cycle, the removal wins and no lock is set.
- R6: A locked read (kind 3) sets `blk_active`=1 and `blk_line` to its line from the next cycle on. A locked write (kind 4) to that same line clears `blk_active`. A locked write to another line leaves the block in place.
- R7: While `bypass_en`=1, every completion gives `res_ok`=1 and neither completions nor permission losses change the lock table.
- R8: The table holds ENTRIES locks. A load-linked to a new line while all entries are in use replaces the entry that was set least recently among those still held. Slots freed by clears are reused first.
- R9: Lines are compared with the low OFFS_W address bits ignored. A load-linked to a line that is already locked re-tags that entry to the new requester instead of adding a second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | Disables the reservation logic |
| cmp_valid | input | 1 | A request completes this cycle |
| cmp_kind | input | 3 | Completion kind (0 LL, 1 SC, 2 store, 3 locked read, 4 locked write) |
| cmp_addr | input | ADDR_W | Byte address of the completing request |
| cmp_req | input | REQ_W | Requester identifier of the completing request |
| cmp_line_present | input | 1 | The line is present in the cache |
| loss_valid | input | 1 | Coherence permission lost on a line |
| loss_addr | input | ADDR_W | Address of the line that lost permission |
| loss_sc_pending | input | 1 | A store-conditional is pending on that line |
| res_valid | output | 1 | Result of the previous cycle's completion |
| res_ok | output | 1 | 1 pass, 0 fail |
| blk_active | output | 1 | A locked read-modify-write holds a line |
| blk_line | output | ADDR_W | Line address being held |

## Verification
The bench sweeps every pair of lock owner and store-conditional requester over every offset within the line. A design that compared full addresses or ignored the tag would show up there as a wrong pass/fail. After each store-conditional it repeats the store-conditional. A design that kept the lock after a failure or a success would pass the repeat. A replacement run fills the table, frees a middle slot, refills it and overflows. A design that used a plain round-robin pointer, or did not reuse freed slots first, would evict a younger line. Other cases cover plain writes by the owner versus another requester or an absent line, permission loss with and without a pending store-conditional, a load-linked and a permission loss landing on the same line together, locked read/write pairs on matching and mismatching lines, and bypass leaving an existing lock untouched.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    K_LL    = 3'd0,
    K_SC    = 3'd1,
    K_STORE = 3'd2,
    K_LRD   = 3'd3,
    K_LWR   = 3'd4
  } cmp_kind_e;
endpackage

// File: rtl/llsc_lock_table.sv
module llsc_lock_table #(
  parameter int ADDR_W  = 8,
  parameter int REQ_W   = 2,
  parameter int ENTRIES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    look_line,
  input  logic [REQ_W-1:0]     look_req,
  output logic [ENTRIES-1:0]   match_vec,
  output logic                 own_any,
  input  logic                 clr0_en,
  input  logic [ADDR_W-1:0]    clr0_line,
  input  logic                 clr1_en,
  input  logic [ADDR_W-1:0]    clr1_line,
  input  logic                 set_en,
  input  logic [ADDR_W-1:0]    set_line,
  input  logic [REQ_W-1:0]     set_req
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int AGE_W = IDX_W;

  logic [ENTRIES-1:0] vld, vld_n, own_vec, clr_vec, keep, set_hit;
  logic [ADDR_W-1:0]  ln   [ENTRIES];
  logic [ADDR_W-1:0]  ln_n [ENTRIES];
  logic [REQ_W-1:0]   rq   [ENTRIES];
  logic [REQ_W-1:0]   rq_n [ENTRIES];
  logic [AGE_W-1:0]   age  [ENTRIES];
  logic [AGE_W-1:0]   age_n[ENTRIES];
  logic               eff_set, upd, alloc, found;
  logic [IDX_W-1:0]   tgt;
  int                 cnt;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      match_vec[i] = vld[i] && (ln[i] == look_line);
      own_vec[i]   = match_vec[i] && (rq[i] == look_req);
      clr_vec[i]   = vld[i] && ((clr0_en && ln[i] == clr0_line) ||
                                (clr1_en && ln[i] == clr1_line));
      keep[i]      = vld[i] && !clr_vec[i];
      set_hit[i]   = keep[i] && (ln[i] == set_line);
    end
    own_any = |own_vec;
    // a clear on the same line beats a set
    eff_set = set_en && !(clr1_en && (set_line == clr1_line));
    upd     = eff_set && (|set_hit);
    alloc   = eff_set && !(|set_hit);
    // free slot first, else the oldest survivor
    tgt   = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!keep[i] && !found) begin
        tgt   = IDX_W'(i);
        found = 1'b1;
      end
    if (!found)
      for (int i = 0; i < ENTRIES; i++)
        if (age[i] == AGE_W'(ENTRIES - 1)) tgt = IDX_W'(i);
    for (int i = 0; i < ENTRIES; i++) begin
      vld_n[i] = keep[i];
      ln_n[i]  = ln[i];
      rq_n[i]  = (upd && set_hit[i]) ? set_req : rq[i];
      cnt = 0;
      for (int j = 0; j < ENTRIES; j++)
        if (keep[j] && !(alloc && IDX_W'(j) == tgt) && (age[j] < age[i]))
          cnt = cnt + 1;
      age_n[i] = AGE_W'(cnt + (alloc ? 1 : 0));
      if (alloc && IDX_W'(i) == tgt) begin
        vld_n[i] = 1'b1;
        ln_n[i]  = set_line;
        rq_n[i]  = set_req;
        age_n[i] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ln[i]  <= '0;
        rq[i]  <= '0;
        age[i] <= '0;
      end
    end else begin
      vld <= vld_n;
      for (int i = 0; i < ENTRIES; i++) begin
        ln[i]  <= ln_n[i];
        rq[i]  <= rq_n[i];
        age[i] <= age_n[i];
      end
    end
  end
endmodule

// File: rtl/llsc_block_ctl.sv
module llsc_block_ctl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lrd_done,
  input  logic              lwr_done,
  input  logic [ADDR_W-1:0] line,
  output logic              blk_active,
  output logic [ADDR_W-1:0] blk_line
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_active <= 1'b0;
      blk_line   <= '0;
    end else if (lrd_done) begin
      blk_active <= 1'b1;
      blk_line   <= line;
    end else if (lwr_done && blk_active && line == blk_line) begin
      blk_active <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int ADDR_W  = 8,
  parameter int OFFS_W  = 2,
  parameter int REQ_W   = 2,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass_en,
  input  logic              cmp_valid,
  input  logic [2:0]        cmp_kind,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [REQ_W-1:0]  cmp_req,
  input  logic              cmp_line_present,
  input  logic              loss_valid,
  input  logic [ADDR_W-1:0] loss_addr,
  input  logic              loss_sc_pending,
  output logic              res_valid,
  output logic              res_ok,
  output logic              blk_active,
  output logic [ADDR_W-1:0] blk_line
);
  import llsc_pkg::*;

  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFFS_W) - ADDR_W'(1));

  function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a & LINE_MASK;
  endfunction

  logic [ADDR_W-1:0]  cmp_line, loss_line;
  logic               ev_ll, ev_sc, ev_wr, ev_lrd, ev_lwr, ev_loss;
  logic               own_any;
  logic [ENTRIES-1:0] match_vec;
  logic               clr0_en;

  assign cmp_line  = line_of(cmp_addr);
  assign loss_line = line_of(loss_addr);
  assign ev_ll   = cmp_valid && cmp_kind == K_LL;
  assign ev_sc   = cmp_valid && cmp_kind == K_SC;
  assign ev_wr   = cmp_valid && cmp_kind != K_LL && cmp_kind != K_SC;
  assign ev_lrd  = cmp_valid && cmp_kind == K_LRD;
  assign ev_lwr  = cmp_valid && cmp_kind == K_LWR;
  assign ev_loss = loss_valid && loss_sc_pending && !bypass_en;
  assign clr0_en = !bypass_en && (ev_sc || (ev_wr && cmp_line_present && own_any));

  llsc_lock_table #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .ENTRIES(ENTRIES)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_line (cmp_line),
    .look_req  (cmp_req),
    .match_vec (match_vec),
    .own_any   (own_any),
    .clr0_en   (clr0_en),
    .clr0_line (cmp_line),
    .clr1_en   (ev_loss),
    .clr1_line (loss_line),
    .set_en    (ev_ll && !bypass_en),
    .set_line  (cmp_line),
    .set_req   (cmp_req)
  );

  llsc_block_ctl #(.ADDR_W(ADDR_W)) u_blk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lrd_done   (ev_lrd),
    .lwr_done   (ev_lwr),
    .line       (cmp_line),
    .blk_active (blk_active),
    .blk_line   (blk_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
    end else begin
      res_valid <= cmp_valid;
      res_ok    <= cmp_valid && (!ev_sc || bypass_en || own_any);
    end
  end
endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk #(
  parameter int ADDR_W  = 8,
  parameter int OFFS_W  = 2,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bypass_en,
  input logic               cmp_valid,
  input logic [2:0]         cmp_kind,
  input logic [ADDR_W-1:0]  cmp_addr,
  input logic               res_valid,
  input logic               res_ok,
  input logic               blk_active,
  input logic [ENTRIES-1:0] match_vec
);
  logic              armed, prev_sc;
  logic [ADDR_W-1:0] prev_line;
  logic              cur_sc;

  assign cur_sc = cmp_valid && cmp_kind == 3'd1 && !bypass_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      prev_sc   <= 1'b0;
      prev_line <= '0;
    end else begin
      armed     <= 1'b1;
      prev_sc   <= cur_sc;
      prev_line <= cmp_addr >> OFFS_W;
    end
  end

  p_res_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> res_valid);
  p_res_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> !res_valid);
  p_nonsc_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind != 3'd1) |=> res_ok);
  p_bypass_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && bypass_en) |=> res_ok);
  p_sc_repeat_fails_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_sc && cur_sc && (cmp_addr >> OFFS_W) == prev_line) |=> !res_ok);
  p_block_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(blk_active)) |-> $past(cmp_valid && cmp_kind == 3'd3));
  p_one_entry_per_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(
  .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bypass_en (bypass_en),
  .cmp_valid (cmp_valid),
  .cmp_kind  (cmp_kind),
  .cmp_addr  (cmp_addr),
  .res_valid (res_valid),
  .res_ok    (res_ok),
  .blk_active(blk_active),
  .match_vec (match_vec)
);

// File: tb/llsc_resv_monitor_tb.sv
module llsc_resv_monitor_tb;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass_en = 1'b0, cmp_valid = 1'b0, cmp_line_present = 1'b0;
  logic [2:0] cmp_kind = '0;
  logic [AW-1:0] cmp_addr = '0, loss_addr = '0;
  logic [1:0] cmp_req = '0;
  logic loss_valid = 1'b0, loss_sc_pending = 1'b0;
  logic res_valid, res_ok, blk_active;
  logic [AW-1:0] blk_line;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  llsc_resv_monitor #(.ADDR_W(AW), .OFFS_W(2), .REQ_W(2), .ENTRIES(4)) u_dut (.*);

  function automatic logic [AW-1:0] la(input int line, input int off);
    return AW'(line * 4 + off);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // starts and ends at a falling edge
  task automatic op(input logic [2:0] k, input logic [AW-1:0] a, input logic [1:0] r,
                    input logic pres, output logic ok);
    cmp_valid = 1'b1; cmp_kind = k; cmp_addr = a; cmp_req = r; cmp_line_present = pres;
    @(negedge clk);
    ok = res_ok;
    if (res_valid !== 1'b1) chk("R1 res_valid", res_valid, 1'b1);
    cmp_valid = 1'b0;
  endtask

  task automatic sc_exp(input string tag, input logic [AW-1:0] a, input logic [1:0] r,
                        input logic exp);
    logic ok;
    op(3'd1, a, r, 1'b1, ok);
    chk(tag, ok, exp);
  endtask

  task automatic loss(input logic [AW-1:0] a, input logic pend);
    loss_valid = 1'b1; loss_addr = a; loss_sc_pending = pend;
    @(negedge clk);
    loss_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset res_valid R1", res_valid, 1'b0);
    chk("reset blk_active R6", blk_active, 1'b0);

    // R2 R3 R9: owner x requester x offset sweep
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int off = 0; off < 4; off++) begin
          op(3'd0, la(9, 0), 2'(a), 1'b1, ok);
          chk("R1 ll passes", ok, 1'b1);
          sc_exp("R2 sc owner match", la(9, off), 2'(b), a == b);
          sc_exp("R3 sc clears lock", la(9, off), 2'(a), 1'b0);
        end

    // R8: fill, free a middle slot, refill, overflow
    for (int l = 1; l <= 4; l++) op(3'd0, la(l, 0), 2'd0, 1'b1, ok);
    sc_exp("R8 free slot 2", la(2, 1), 2'd0, 1'b1);
    op(3'd0, la(5, 0), 2'd0, 1'b1, ok);
    op(3'd0, la(6, 0), 2'd0, 1'b1, ok);
    sc_exp("R8 oldest evicted", la(1, 0), 2'd0, 1'b0);
    sc_exp("R8 line3 kept", la(3, 0), 2'd0, 1'b1);
    sc_exp("R8 line4 kept", la(4, 0), 2'd0, 1'b1);
    sc_exp("R8 line5 kept", la(5, 0), 2'd0, 1'b1);
    sc_exp("R8 line6 kept", la(6, 0), 2'd0, 1'b1);

    // R4: plain writes
    op(3'd0, la(7, 0), 2'd1, 1'b1, ok);
    op(3'd2, la(7, 2), 2'd2, 1'b1, ok);
    chk("R1 store passes", ok, 1'b1);
    sc_exp("R4 other req keeps", la(7, 0), 2'd1, 1'b1);
    op(3'd0, la(7, 0), 2'd1, 1'b1, ok);
    op(3'd2, la(7, 0), 2'd1, 1'b0, ok);
    sc_exp("R4 absent line keeps", la(7, 0), 2'd1, 1'b1);
    op(3'd0, la(7, 0), 2'd1, 1'b1, ok);
    op(3'd2, la(7, 3), 2'd1, 1'b1, ok);
    sc_exp("R4 owner store clears", la(7, 0), 2'd1, 1'b0);

    // R5: permission loss
    op(3'd0, la(8, 0), 2'd3, 1'b1, ok);
    loss(la(8, 1), 1'b0);
    sc_exp("R5 no pending keeps", la(8, 0), 2'd3, 1'b1);
    op(3'd0, la(8, 0), 2'd3, 1'b1, ok);
    loss(la(8, 2), 1'b1);
    sc_exp("R5 pending clears", la(8, 0), 2'd3, 1'b0);
    loss_valid = 1'b1; loss_addr = la(8, 3); loss_sc_pending = 1'b1;
    op(3'd0, la(8, 0), 2'd3, 1'b1, ok);
    loss_valid = 1'b0;
    sc_exp("R5 clear beats set", la(8, 0), 2'd3, 1'b0);

    // R9: retag on re-lock
    op(3'd0, la(10, 0), 2'd0, 1'b1, ok);
    op(3'd0, la(10, 1), 2'd1, 1'b1, ok);
    sc_exp("R9 retagged owner", la(10, 0), 2'd1, 1'b1);

    // R6: locked read-modify-write blocking
    op(3'd3, la(7, 1), 2'd0, 1'b1, ok);
    chk("R6 block set", blk_active, 1'b1);
    chk("R6 block line", blk_line == la(7, 0), 1'b1);
    op(3'd4, la(3, 0), 2'd0, 1'b1, ok);
    chk("R6 other line keeps block", blk_active, 1'b1);
    op(3'd4, la(7, 3), 2'd0, 1'b1, ok);
    chk("R1 locked write passes", ok, 1'b1);
    chk("R6 block released", blk_active, 1'b0);

    // R7: bypass
    bypass_en = 1'b1;
    sc_exp("R7 bypass sc passes", la(11, 0), 2'd0, 1'b1);
    op(3'd0, la(12, 0), 2'd2, 1'b1, ok);
    bypass_en = 1'b0;
    sc_exp("R7 bypass ll set nothing", la(12, 0), 2'd2, 1'b0);
    op(3'd0, la(13, 0), 2'd2, 1'b1, ok);
    bypass_en = 1'b1;
    sc_exp("R7 bypass sc passes 2", la(13, 0), 2'd2, 1'b1);
    loss(la(13, 0), 1'b1);
    bypass_en = 1'b0;
    sc_exp("R7 lock untouched", la(13, 0), 2'd2, 1'b1);

    @(negedge clk);
    chk("R1 idle res_valid", res_valid, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule